// File: doc/BRIEF.md
# SDIO Direct Register Access Responder

This block is the card-side executor for single-register read/write commands. A command front end has already received the 32-bit command argument and checked its CRC. It presents the argument with a one-cycle strobe, together with a CRC-error flag and an illegal-command flag. The responder decodes the argument and reads or writes one byte in a small common control space or in the per-function basic register space. One clock later it presents a 16-bit status word and an 8-bit data byte for the response frame.

Argument layout: bit 31 is the write flag (1 = write), bits 30:28 are the function number, bit 27 asks for read-after-write, bits 25:9 are the 17-bit register address and bits 7:0 carry the write data. Bits 26 and 8 are ignored. The common space sits at addresses 0x00 to 0xFF. Function f (1 to NUM_FUNCS) owns the basic registers starting at f × 0x100.

The block drives the data bus width, the interrupt enables, a per-function abort pulse and a card reset pulse straight from its register state. Status bits follow their own clear rules. Errors flagged by the front end are reported one command late. Execution errors are reported in the response to the command that caused them and are then cleared.

Top module: `sdio_direct_responder`

## Requirements
- R1: A strobe with neither front-end flag set produces `rsp_vld_o` high for exactly the next cycle. For a read, `rsp_data_o` carries the addressed register's contents. Register 0x00 reads the constant REV_BYTE (default 0x32).
- R2: For a write with bit 27 set, `rsp_data_o` is the register value after the write. For a write with bit 27 clear, it is the value before the write.
- R3: A strobe with `crc_err_i` or `illegal_i` high performs no access and produces no response. The next good command's response shows status bit 15 (CRC) or bit 14 (illegal). The response after that shows them clear again.
- R4: A function number greater than NUM_FUNCS sets status bit 9, performs no write and returns data 0x00.
- R5: An unmapped address sets status bit 8, performs no write and returns data 0x00. Unmapped addresses are: address bits 16:12 nonzero, a function block above NUM_FUNCS, an unlisted common offset, or a basic-register offset other than 0x00, 0x10 or 0x11.
- R6: A write to a read-only register (0x00, 0x05, 0x08) sets status bit 11 and leaves the register unchanged. Register 0x08 reads CAPS_BYTE (default 0x03).
- R7: Status bits 11, 9 and 8 appear only in the response to the command that raised them. The following good command's response has them clear.
- R8: Status bits 13:12 read 01 when `xfer_busy_i` is low at the strobe and 10 when it is high. Bit 10 and bits 7:0 are always 0.
- R9: Register 0x07 bits 1:0 set `bus_width_o` (00 = 1-bit, 10 = 4-bit, 11 stored as written). Writing 01 keeps the previous width. The register resets to 00.
- R10: Register 0x04 bit 0 is the master interrupt enable and bits NUM_FUNCS:1 are the function enables. All of them drive `int_en_o` and reset to 0. Register 0x05 reads `int_pend_i[f-1]` in bit f and 0 in bit 0.
- R11: A write to register 0x06 with bit 3 set pulses `card_rst_o` for one cycle. A value f in 1..NUM_FUNCS in bits 2:0 pulses `abort_o[f-1]` for one cycle. Both pulses coincide with `rsp_vld_o`, and the register reads 0x00.
- R12: Each function f has read/write bytes at f×0x100 + 0x00, 0x10 and 0x11. These reset to 0x00 and are separate per function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld_i | input | 1 | One-cycle command strobe |
| cmd_arg_i | input | 32 | Command argument |
| crc_err_i | input | 1 | Front end saw a CRC error on this command |
| illegal_i | input | 1 | Front end judged this command illegal |
| xfer_busy_i | input | 1 | A data transfer is in progress |
| int_pend_i | input | NUM_FUNCS | Per-function interrupt pending |
| rsp_vld_o | output | 1 | Response fields valid |
| rsp_status_o | output | 16 | Response status word |
| rsp_data_o | output | 8 | Response data byte |
| bus_width_o | output | 2 | Data bus width setting |
| int_en_o | output | NUM_FUNCS+1 | Bit 0 master enable, bits NUM_FUNCS:1 function enables |
| abort_o | output | NUM_FUNCS | Per-function abort pulse |
| card_rst_o | output | 1 | Card reset pulse |

## Verification
The assertions assume that the strobe lasts one cycle and that the front-end flags are meaningful only while it is high. They also assume that the argument is stable during the strobe cycle. The bench drives every command on the falling edge, holds the strobe for exactly one cycle, and returns it low before sampling the response half a cycle after the capturing edge. Error commands, bad flags and transfer-busy cases are each issued on their own, so that one status bit is attributable to one command.

// File: rtl/sdio_dr_pkg.sv
package sdio_dr_pkg;

    typedef enum logic [2:0] {
        T_NONE, T_REV, T_IEN, T_PEND, T_ABORT, T_BUS, T_CAPS, T_FBR
    } tgt_e;

    typedef struct packed {
        logic        wr;
        logic [2:0]  fn;
        logic        raw;
        logic [16:0] addr;
        logic [7:0]  wdata;
    } cmd_arg_t;

    typedef struct packed {
        tgt_e       tgt;
        logic [2:0] fsel;
        logic [1:0] slot;
        logic       fn_err;
        logic       rng_err;
        logic       ro_err;
    } dec_t;

    localparam logic [7:0] OFS_REV   = 8'h00;
    localparam logic [7:0] OFS_IEN   = 8'h04;
    localparam logic [7:0] OFS_PEND  = 8'h05;
    localparam logic [7:0] OFS_ABORT = 8'h06;
    localparam logic [7:0] OFS_BUS   = 8'h07;
    localparam logic [7:0] OFS_CAPS  = 8'h08;

    localparam logic [7:0] FOFS_IF   = 8'h00;
    localparam logic [7:0] FOFS_BLO  = 8'h10;
    localparam logic [7:0] FOFS_BHI  = 8'h11;

    localparam logic [1:0] ST_CMD    = 2'b01;
    localparam logic [1:0] ST_XFER   = 2'b10;

    function automatic logic [15:0] pack_status(logic crc, logic ill, logic [1:0] st,
                                                logic gen, logic fne, logic rng);
        return {crc, ill, st, gen, 1'b0, fne, rng, 8'h00};
    endfunction

endpackage

// File: rtl/dr_decode.sv
module dr_decode
    import sdio_dr_pkg::*;
#(
    parameter int NUM_FUNCS = 2
) (
    input  cmd_arg_t arg,
    output dec_t     dec
);
    localparam logic [3:0] NF4 = 4'(NUM_FUNCS);

    always_comb begin
        dec      = '0;
        dec.tgt  = T_NONE;
        dec.fsel = arg.addr[10:8];
        if ({1'b0, arg.fn} > NF4) begin
            dec.fn_err = 1'b1;
        end else if (arg.addr[16:12] != '0 || arg.addr[11:8] > NF4) begin
            dec.rng_err = 1'b1;
        end else if (arg.addr[11:8] == 4'd0) begin
            case (arg.addr[7:0])
                OFS_REV:   begin dec.tgt = T_REV;   dec.ro_err = arg.wr; end
                OFS_IEN:   dec.tgt = T_IEN;
                OFS_PEND:  begin dec.tgt = T_PEND;  dec.ro_err = arg.wr; end
                OFS_ABORT: dec.tgt = T_ABORT;
                OFS_BUS:   dec.tgt = T_BUS;
                OFS_CAPS:  begin dec.tgt = T_CAPS;  dec.ro_err = arg.wr; end
                default:   dec.rng_err = 1'b1;
            endcase
        end else begin
            case (arg.addr[7:0])
                FOFS_IF:  begin dec.tgt = T_FBR; dec.slot = 2'd0; end
                FOFS_BLO: begin dec.tgt = T_FBR; dec.slot = 2'd1; end
                FOFS_BHI: begin dec.tgt = T_FBR; dec.slot = 2'd2; end
                default:  dec.rng_err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dr_regs.sv
module dr_regs
    import sdio_dr_pkg::*;
#(
    parameter int         NUM_FUNCS = 2,
    parameter logic [7:0] REV_BYTE  = 8'h32,
    parameter logic [7:0] CAPS_BYTE = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  tgt_e                 tgt,
    input  logic [2:0]           fsel,
    input  logic [1:0]           slot,
    input  logic [7:0]           wdata,
    input  logic [NUM_FUNCS-1:0] int_pend_i,
    output logic [7:0]           rd_old,
    output logic [7:0]           rd_new,
    output logic [1:0]           bus_width_o,
    output logic [NUM_FUNCS:0]   int_en_o,
    output logic [NUM_FUNCS-1:0] abort_o,
    output logic                 card_rst_o
);
    logic [NUM_FUNCS:0]   ien_q, ien_d;
    logic [1:0]           bw_q, bw_d;
    logic [23:0]          fbr_rd [NUM_FUNCS];
    logic [23:0]          fbr_sel;
    logic [7:0]           fbr_old, fbr_new;
    logic [NUM_FUNCS-1:0] abort_q;
    logic                 rst_q;

    // Per-function basic register storage
    for (genvar g = 1; g <= NUM_FUNCS; g++) begin : g_fbr
        logic [7:0] byte_q [3];
        logic       sel;
        assign sel = wr_en && tgt == T_FBR && fsel == 3'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < 3; s++) byte_q[s] <= 8'h00;
            end else if (sel) begin
                byte_q[slot] <= wdata;
            end
        end
        assign fbr_rd[g-1] = {byte_q[2], byte_q[1], byte_q[0]};
    end

    always_comb begin
        fbr_sel = '0;
        for (int i = 0; i < NUM_FUNCS; i++)
            if (fsel == 3'(i + 1)) fbr_sel = fbr_rd[i];
        fbr_old = fbr_sel[8*slot +: 8];
        fbr_new = (wr_en && tgt == T_FBR) ? wdata : fbr_old;
        ien_d   = (wr_en && tgt == T_IEN) ? wdata[NUM_FUNCS:0] : ien_q;
        bw_d    = (wr_en && tgt == T_BUS && wdata[1:0] != 2'b01) ? wdata[1:0] : bw_q;
    end

    function automatic logic [7:0] view(tgt_e t, logic [NUM_FUNCS:0] ien,
                                        logic [1:0] bw, logic [7:0] fb);
        case (t)
            T_REV:   return REV_BYTE;
            T_IEN:   return 8'(ien);
            T_PEND:  return 8'({int_pend_i, 1'b0});
            T_BUS:   return {6'b0, bw};
            T_CAPS:  return CAPS_BYTE;
            T_FBR:   return fb;
            default: return 8'h00;
        endcase
    endfunction

    assign rd_old = view(tgt, ien_q, bw_q, fbr_old);
    assign rd_new = view(tgt, ien_d, bw_d, fbr_new);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            bw_q    <= 2'b00;
            abort_q <= '0;
            rst_q   <= 1'b0;
        end else begin
            ien_q   <= ien_d;
            bw_q    <= bw_d;
            abort_q <= '0;
            rst_q   <= 1'b0;
            if (wr_en && tgt == T_ABORT) begin
                rst_q <= wdata[3];
                for (int i = 0; i < NUM_FUNCS; i++)
                    abort_q[i] <= (wdata[2:0] == 3'(i + 1));
            end
        end
    end

    assign bus_width_o = bw_q;
    assign int_en_o    = ien_q;
    assign abort_o     = abort_q;
    assign card_rst_o  = rst_q;
endmodule

// File: rtl/dr_status.sv
module dr_status
    import sdio_dr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_vld_i,
    input  logic        crc_err_i,
    input  logic        illegal_i,
    input  logic        xfer_busy_i,
    input  logic        fn_err,
    input  logic        rng_err,
    input  logic        ro_err,
    input  logic [7:0]  data_i,
    output logic        rsp_vld_o,
    output logic [15:0] rsp_status_o,
    output logic [7:0]  rsp_data_o
);
    logic crc_q, ill_q;
    logic good;

    assign good = cmd_vld_i && !crc_err_i && !illegal_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q        <= 1'b0;
            ill_q        <= 1'b0;
            rsp_vld_o    <= 1'b0;
            rsp_status_o <= '0;
            rsp_data_o   <= '0;
        end else begin
            rsp_vld_o <= good;
            if (cmd_vld_i && (crc_err_i || illegal_i)) begin
                crc_q <= crc_q | crc_err_i;
                ill_q <= ill_q | illegal_i;
            end else if (good) begin
                rsp_status_o <= pack_status(crc_q, ill_q,
                                            xfer_busy_i ? ST_XFER : ST_CMD,
                                            ro_err, fn_err, rng_err);
                rsp_data_o   <= data_i;
                crc_q        <= 1'b0;
                ill_q        <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdio_direct_responder.sv
module sdio_direct_responder
    import sdio_dr_pkg::*;
#(
    parameter int         NUM_FUNCS = 2,
    parameter logic [7:0] REV_BYTE  = 8'h32,
    parameter logic [7:0] CAPS_BYTE = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_vld_i,
    input  logic [31:0]          cmd_arg_i,
    input  logic                 crc_err_i,
    input  logic                 illegal_i,
    input  logic                 xfer_busy_i,
    input  logic [NUM_FUNCS-1:0] int_pend_i,
    output logic                 rsp_vld_o,
    output logic [15:0]          rsp_status_o,
    output logic [7:0]           rsp_data_o,
    output logic [1:0]           bus_width_o,
    output logic [NUM_FUNCS:0]   int_en_o,
    output logic [NUM_FUNCS-1:0] abort_o,
    output logic                 card_rst_o
);
    cmd_arg_t   arg;
    dec_t       dec;
    logic       good, wr_en, blocked;
    logic [7:0] rd_old, rd_new, rsp_byte;
    logic [1:0] unused_stuff;

    assign arg          = {cmd_arg_i[31], cmd_arg_i[30:28], cmd_arg_i[27],
                           cmd_arg_i[25:9], cmd_arg_i[7:0]};
    assign unused_stuff = {cmd_arg_i[26], cmd_arg_i[8]};

    dr_decode #(.NUM_FUNCS(NUM_FUNCS)) u_dec (.arg(arg), .dec(dec));

    assign good    = cmd_vld_i && !crc_err_i && !illegal_i;
    assign blocked = dec.fn_err || dec.rng_err || dec.ro_err;
    assign wr_en   = good && arg.wr && !blocked;

    dr_regs #(
        .NUM_FUNCS(NUM_FUNCS), .REV_BYTE(REV_BYTE), .CAPS_BYTE(CAPS_BYTE)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .tgt(dec.tgt), .fsel(dec.fsel),
        .slot(dec.slot), .wdata(arg.wdata), .int_pend_i(int_pend_i),
        .rd_old(rd_old), .rd_new(rd_new), .bus_width_o(bus_width_o),
        .int_en_o(int_en_o), .abort_o(abort_o), .card_rst_o(card_rst_o)
    );

    assign rsp_byte = (dec.fn_err || dec.rng_err) ? 8'h00 :
                      (arg.wr && arg.raw)         ? rd_new : rd_old;

    dr_status u_stat (
        .clk(clk), .rst(rst), .cmd_vld_i(cmd_vld_i), .crc_err_i(crc_err_i),
        .illegal_i(illegal_i), .xfer_busy_i(xfer_busy_i), .fn_err(dec.fn_err),
        .rng_err(dec.rng_err), .ro_err(dec.ro_err), .data_i(rsp_byte),
        .rsp_vld_o(rsp_vld_o), .rsp_status_o(rsp_status_o), .rsp_data_o(rsp_data_o)
    );
endmodule

// File: rtl/dr_checker.sv
module dr_checker #(
    parameter int NUM_FUNCS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_vld_i,
    input logic                 crc_err_i,
    input logic                 illegal_i,
    input logic                 rsp_vld_o,
    input logic [15:0]          rsp_status_o,
    input logic [7:0]           rsp_data_o,
    input logic [1:0]           bus_width_o,
    input logic [NUM_FUNCS-1:0] abort_o,
    input logic                 card_rst_o
);
    a_r1_rsp_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_vld_i && !crc_err_i && !illegal_i |=> rsp_vld_o);

    a_r3_no_rsp_on_bad: assert property (@(posedge clk) disable iff (rst)
        cmd_vld_i && (crc_err_i || illegal_i) |=> !rsp_vld_o);

    a_r4_fn_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        rsp_vld_o && rsp_status_o[9] |-> !rsp_status_o[8] && !rsp_status_o[11] && rsp_data_o == 8'h00);

    a_r5_range_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_vld_o && rsp_status_o[8] |-> rsp_data_o == 8'h00);

    a_r8_state_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_vld_o |-> (rsp_status_o[13:12] == 2'b01 || rsp_status_o[13:12] == 2'b10)
                      && !rsp_status_o[10] && rsp_status_o[7:0] == 8'h00);

    a_r9_width_not_reserved: assert property (@(posedge clk) disable iff (rst)
        bus_width_o != 2'b01);

    a_r11_abort_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(abort_o));

    a_r11_pulse_with_rsp: assert property (@(posedge clk) disable iff (rst)
        (abort_o != '0 || card_rst_o) |-> rsp_vld_o);
endmodule

bind sdio_direct_responder dr_checker #(.NUM_FUNCS(NUM_FUNCS)) u_chk (.*);

// File: tb/test_sdio_direct_responder.sv
module test_sdio_direct_responder;
    localparam int NF = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_vld_i = 1'b0;
    logic [31:0]   cmd_arg_i = '0;
    logic          crc_err_i = 1'b0;
    logic          illegal_i = 1'b0;
    logic          xfer_busy_i = 1'b0;
    logic [NF-1:0] int_pend_i = '0;
    logic          rsp_vld_o;
    logic [15:0]   rsp_status_o;
    logic [7:0]    rsp_data_o;
    logic [1:0]    bus_width_o;
    logic [NF:0]   int_en_o;
    logic [NF-1:0] abort_o;
    logic          card_rst_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    sdio_direct_responder #(.NUM_FUNCS(NF)) i_sdio_direct_responder (.*);

    always #2.5 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit wr, bit [2:0] fn, bit raw, bit [16:0] a, bit [7:0] d);
        return {wr, fn, raw, 1'b0, a, 1'b0, d};
    endfunction

    // Issue one command; outputs are sampled half a cycle after the capturing edge
    task automatic cmd(bit wr, bit [2:0] fn, bit raw, bit [16:0] a, bit [7:0] d,
                       bit crc = 0, bit ill = 0);
        @(negedge clk);
        cmd_arg_i = mk(wr, fn, raw, a, d);
        crc_err_i = crc;
        illegal_i = ill;
        cmd_vld_i = 1'b1;
        @(negedge clk);
        cmd_vld_i = 1'b0;
        crc_err_i = 1'b0;
        illegal_i = 1'b0;
    endtask

    task automatic rsp_chk(string req, int st, int d);
        chk(req, "rsp_vld", int'(rsp_vld_o), 1);
        chk(req, "status", int'(rsp_status_o), st);
        chk(req, "data", int'(rsp_data_o), d);
    endtask

    task automatic t_reset;
        chk("R1", "rsp_vld after reset", int'(rsp_vld_o), 0);
        chk("R9", "bus width reset", int'(bus_width_o), 0);
        chk("R10", "int enables reset", int'(int_en_o), 0);
        chk("R11", "abort reset", int'(abort_o), 0);
        chk("R11", "card reset idle", int'(card_rst_o), 0);
    endtask

    task automatic t_read_const;
        cmd(0, 0, 0, 17'h00000, 8'h00);
        rsp_chk("R1", 16'h1000, 8'h32);
        @(negedge clk);
        chk("R1", "rsp_vld one cycle", int'(rsp_vld_o), 0);
        cmd(0, 0, 0, 17'h00008, 8'h00);
        rsp_chk("R6", 16'h1000, 8'h03);
    endtask

    task automatic t_raw;
        cmd(1, 0, 1, 17'h00004, 8'h05);
        rsp_chk("R2", 16'h1000, 8'h05);
        chk("R10", "int_en after write", int'(int_en_o), 3'b101);
        cmd(1, 0, 0, 17'h00004, 8'hFF);
        rsp_chk("R2", 16'h1000, 8'h05);
        chk("R10", "int_en masked", int'(int_en_o), 3'b111);
        cmd(0, 0, 0, 17'h00004, 8'h00);
        rsp_chk("R10", 16'h1000, 8'h07);
    endtask

    task automatic t_width;
        cmd(1, 0, 1, 17'h00007, 8'h02);
        rsp_chk("R9", 16'h1000, 8'h02);
        chk("R9", "width 4-bit", int'(bus_width_o), 2);
        cmd(1, 0, 1, 17'h00007, 8'h01);
        rsp_chk("R9", 16'h1000, 8'h02);
        chk("R9", "reserved ignored", int'(bus_width_o), 2);
        cmd(1, 0, 0, 17'h00007, 8'h00);
        chk("R9", "width 1-bit", int'(bus_width_o), 0);
    endtask

    task automatic t_abort;
        cmd(1, 0, 1, 17'h00006, 8'h08);
        rsp_chk("R11", 16'h1000, 8'h00);
        chk("R11", "card reset pulse", int'(card_rst_o), 1);
        chk("R11", "no abort on reset", int'(abort_o), 0);
        @(negedge clk);
        chk("R11", "card reset one cycle", int'(card_rst_o), 0);
        cmd(1, 0, 0, 17'h00006, 8'h02);
        chk("R11", "abort func 2", int'(abort_o), 2'b10);
        chk("R11", "no reset on abort", int'(card_rst_o), 0);
        @(negedge clk);
        chk("R11", "abort one cycle", int'(abort_o), 0);
        cmd(1, 0, 0, 17'h00006, 8'h05);
        chk("R11", "abort unimplemented func", int'(abort_o), 0);
        cmd(0, 0, 0, 17'h00006, 8'h00);
        rsp_chk("R11", 16'h1000, 8'h00);
    endtask

    task automatic t_pend;
        int_pend_i = 2'b10;
        cmd(0, 0, 0, 17'h00005, 8'h00);
        rsp_chk("R10", 16'h1000, 8'h04);
        int_pend_i = 2'b01;
        cmd(0, 0, 0, 17'h00005, 8'h00);
        rsp_chk("R10", 16'h1000, 8'h02);
        int_pend_i = '0;
    endtask

    task automatic t_fbr;
        cmd(1, 0, 1, 17'h00210, 8'hAB);
        rsp_chk("R12", 16'h1000, 8'hAB);
        cmd(1, 0, 0, 17'h00111, 8'h5C);
        cmd(0, 0, 0, 17'h00110, 8'h00);
        rsp_chk("R12", 16'h1000, 8'h00);
        cmd(0, 0, 0, 17'h00111, 8'h00);
        rsp_chk("R12", 16'h1000, 8'h5C);
        cmd(0, 0, 0, 17'h00210, 8'h00);
        rsp_chk("R12", 16'h1000, 8'hAB);
    endtask

    task automatic t_fn_err;
        cmd(1, 5, 1, 17'h00004, 8'h00);
        rsp_chk("R4", 16'h1200, 8'h00);
        cmd(0, 0, 0, 17'h00004, 8'h00);
        rsp_chk("R7", 16'h1000, 8'h07);
    endtask

    task automatic t_range;
        cmd(1, 0, 1, 17'h00310, 8'h11);
        rsp_chk("R5", 16'h1100, 8'h00);
        cmd(0, 0, 0, 17'h00020, 8'h00);
        rsp_chk("R5", 16'h1100, 8'h00);
        cmd(1, 0, 0, 17'h10210, 8'h22);
        rsp_chk("R5", 16'h1100, 8'h00);
        cmd(1, 0, 0, 17'h00205, 8'h33);
        rsp_chk("R5", 16'h1100, 8'h00);
        cmd(0, 0, 0, 17'h00210, 8'h00);
        rsp_chk("R7", 16'h1000, 8'hAB);
    endtask

    task automatic t_ro;
        cmd(1, 0, 1, 17'h00008, 8'h00);
        rsp_chk("R6", 16'h1800, 8'h03);
        cmd(0, 0, 0, 17'h00008, 8'h00);
        rsp_chk("R7", 16'h1000, 8'h03);
    endtask

    task automatic t_front_flags;
        cmd(1, 0, 0, 17'h00007, 8'h02, 1, 0);
        chk("R3", "no rsp on crc error", int'(rsp_vld_o), 0);
        chk("R3", "no write on crc error", int'(bus_width_o), 0);
        cmd(0, 0, 0, 17'h00007, 8'h00);
        rsp_chk("R3", 16'h9000, 8'h00);
        cmd(0, 0, 0, 17'h00007, 8'h00);
        rsp_chk("R3", 16'h1000, 8'h00);
        cmd(1, 0, 0, 17'h00004, 8'h00, 0, 1);
        chk("R3", "no rsp on illegal", int'(rsp_vld_o), 0);
        cmd(0, 0, 0, 17'h00004, 8'h00);
        rsp_chk("R3", 16'h5000, 8'h07);
        cmd(0, 0, 0, 17'h00004, 8'h00);
        rsp_chk("R3", 16'h1000, 8'h07);
    endtask

    task automatic t_state;
        xfer_busy_i = 1'b1;
        cmd(0, 0, 0, 17'h00000, 8'h00);
        rsp_chk("R8", 16'h2000, 8'h32);
        xfer_busy_i = 1'b0;
        cmd(0, 0, 0, 17'h00000, 8'h00);
        rsp_chk("R8", 16'h1000, 8'h32);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_const();
        t_raw();
        t_width();
        t_abort();
        t_pend();
        t_fbr();
        t_fn_err();
        t_range();
        t_ro();
        t_front_flags();
        t_state();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule